// File: doc/BRIEF.md
# Receive Buffer Descriptor Engine

This block places an incoming byte-stream frame into memory buffers chosen by a ring of descriptors. Each descriptor occupies 8 bytes of a small descriptor RAM. The first 32-bit word holds a 16-bit status half (bits 31:16) and a 16-bit length half (bits 15:0). The second word, at offset +4, holds the 32-bit buffer address. Host software arms a descriptor by setting its empty bit. The engine fills the buffer one byte per accepted input cycle. When the buffer is done, the engine writes the first word back with the length and the final status, and the empty bit cleared.

A frame can cover several buffers. A buffer closes when it reaches the programmed buffer length or when the frame ends, and the frame then continues in the next descriptor. While a buffer is filling, the engine reads the next descriptor ahead of time, so that the move to the next buffer costs no cycles. The frame port cannot stall. If a byte arrives and no armed descriptor is held, the engine reports a busy error and discards the rest of that frame. Because of the read-ahead, a ring needs at least two descriptors to keep running.

Top module: `rxbd_engine`

## Requirements
- R1: After reset, the engine produces no buffer writes, no interrupt and no error pulse. Its first descriptor RAM access is a read at `tbl_base`.
- R2: Descriptors are 8 bytes apart, starting at `tbl_base`. After a descriptor whose wrap bit (status bit 13, word bit 29) is set, the walk returns to `tbl_base`.
- R3: Byte k of a buffer is written at buffer address + k, and `bw_valid` is raised the cycle after the byte is accepted.
- R4: A buffer closes after `buf_len` bytes and the frame continues in the next descriptor. A frame of exactly `buf_len` bytes uses one buffer.
- R5: Write-back status: empty (bit 15) is cleared and wrap (bit 13) is kept. Last (bit 11) is set only on the buffer that ends the frame. First (bit 10) is set only on the frame's first buffer. All other status bits are zero.
- R6: The length half holds the byte count for a buffer that is not last. For the last buffer it holds the total frame length.
- R7: A byte that needs a new buffer when no armed descriptor is held raises `err_busy` for one cycle. No byte of that frame from that point on is written, and no descriptor is written back for it.
- R8: A descriptor read while not empty is read again until it is armed. Reception then resumes in it, and the next frame starts with the first bit set.
- R9: `irq_frame` pulses for one cycle, in the cycle after the last byte of a stored frame is accepted.
- R10: A two-descriptor ring carries back-to-back frames as long as each descriptor is re-armed before it is needed again.
- R11: A write-back touches only the descriptor's first word, so the buffer address word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_base | input | DA_W | Byte address of the first descriptor, 8-byte aligned |
| buf_len | input | 16 | Maximum bytes per buffer |
| dram_req | output | 1 | Descriptor RAM access strobe |
| dram_we | output | 1 | Descriptor RAM write enable |
| dram_addr | output | DA_W | Descriptor RAM byte address (word aligned) |
| dram_wdata | output | 32 | Descriptor RAM write data |
| dram_rdata | input | 32 | Descriptor RAM read data, one cycle after the read |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Byte ends the frame |
| bw_valid | output | 1 | Buffer byte write strobe |
| bw_addr | output | 32 | Buffer byte write address |
| bw_data | output | 8 | Buffer byte write data |
| irq_frame | output | 1 | Frame stored pulse |
| err_busy | output | 1 | Busy error pulse |

## Verification
The assertions assume the following about the inputs:
- `tbl_base` is 8-byte aligned and does not change outside reset.
- `buf_len` is at least 8, so the two-read fetch of the next descriptor finishes before that descriptor is needed.
- No frame is longer than 65535 bytes.

The stimulus keeps to these limits:
- It sets the base and length only while reset is held.
- It uses a buffer length of 8 and frames of at most 20 bytes.
- It re-arms descriptors at falling edges between frames, never during a frame that needs them, except in the cases that test the busy error on purpose.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    // Status bit positions inside the 16-bit status half of word 0.
    localparam int ST_EMPTY = 15;
    localparam int ST_WRAP  = 13;
    localparam int ST_LAST  = 11;
    localparam int ST_FIRST = 10;

    // Fixed descriptor format widths and layout.
    localparam int DESC_BYTES = 8;
    localparam int PTR_OFS    = 4;
    localparam int LEN_W      = 16;
    localparam int PTR_W      = 32;

    typedef struct packed {
        logic [15:0]      status;
        logic [LEN_W-1:0] length;
    } desc_w0_t;

    typedef enum logic [1:0] {
        PF_IDLE,
        PF_CAP0,
        PF_ISS1,
        PF_CAP1
    } pf_state_e;

    function automatic logic [15:0] make_status(input logic wrap,
                                                input logic last,
                                                input logic first);
        logic [15:0] s;
        s           = '0;
        s[ST_WRAP]  = wrap;
        s[ST_LAST]  = last;
        s[ST_FIRST] = first;
        return s;
    endfunction

endpackage

// File: rtl/rxbd_prefetch.sv
module rxbd_prefetch
    import rxbd_pkg::*;
#(
    parameter int DA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DA_W-1:0]  tbl_base,
    input  logic             grant,
    output logic             rd_req,
    output logic [DA_W-1:0]  rd_addr,
    input  logic [31:0]      rd_data,
    input  logic             take,
    output logic             pf_valid,
    output logic [DA_W-1:0]  pf_addr,
    output logic [PTR_W-1:0] pf_ptr,
    output logic             pf_wrap
);

    localparam logic [DA_W-1:0] STEP   = DA_W'(DESC_BYTES);
    localparam logic [DA_W-1:0] W1_OFS = DA_W'(PTR_OFS);
    localparam int EMPTY_BIT = LEN_W + ST_EMPTY;
    localparam int WRAP_BIT  = LEN_W + ST_WRAP;

    pf_state_e       state;
    logic [DA_W-1:0] fetch_addr;
    logic            seen_empty;

    assign pf_addr    = fetch_addr;
    assign seen_empty = rd_data[EMPTY_BIT];

    always_comb begin
        rd_req  = 1'b0;
        rd_addr = fetch_addr;
        unique case (state)
            PF_IDLE: rd_req = !pf_valid && grant;
            PF_CAP0: begin
                rd_req  = seen_empty && grant;
                rd_addr = fetch_addr + W1_OFS;
            end
            PF_ISS1: begin
                rd_req  = grant;
                rd_addr = fetch_addr + W1_OFS;
            end
            default: rd_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PF_IDLE;
            fetch_addr <= tbl_base;
            pf_valid   <= 1'b0;
            pf_ptr     <= '0;
            pf_wrap    <= 1'b0;
        end else begin
            unique case (state)
                PF_IDLE: if (rd_req) state <= PF_CAP0;
                PF_CAP0: begin
                    pf_wrap <= rd_data[WRAP_BIT];
                    if (!seen_empty)  state <= PF_IDLE;
                    else if (rd_req)  state <= PF_CAP1;
                    else              state <= PF_ISS1;
                end
                PF_ISS1: if (rd_req) state <= PF_CAP1;
                default: begin
                    pf_ptr   <= rd_data;
                    pf_valid <= 1'b1;
                    state    <= PF_IDLE;
                end
            endcase
            if (take) begin
                pf_valid   <= 1'b0;
                fetch_addr <= pf_wrap ? tbl_base : fetch_addr + STEP;
            end
        end
    end

endmodule

// File: rtl/rxbd_fill.sv
module rxbd_fill
    import rxbd_pkg::*;
#(
    parameter int DA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic [LEN_W-1:0] buf_len,
    input  logic             pf_valid,
    input  logic [DA_W-1:0]  pf_addr,
    input  logic [PTR_W-1:0] pf_ptr,
    input  logic             pf_wrap,
    output logic             take,
    output logic             close,
    output logic [DA_W-1:0]  close_addr,
    output desc_w0_t         close_word,
    output logic             bw_valid,
    output logic [PTR_W-1:0] bw_addr,
    output logic [7:0]       bw_data,
    output logic             irq_frame,
    output logic             err_busy
);

    logic             act_valid;
    logic [DA_W-1:0]  act_addr;
    logic [PTR_W-1:0] act_ptr;
    logic             act_wrap;
    logic [LEN_W-1:0] act_cnt;
    logic [LEN_W-1:0] frame_len;
    logic             first_pend;
    logic             dropping;

    logic             have, accept, busy;
    logic             use_wrap;
    logic [PTR_W-1:0] use_ptr;
    logic [LEN_W-1:0] base_cnt, cnt_n, flen_n;

    always_comb begin
        have       = act_valid || pf_valid;
        accept     = rx_valid && !dropping && have;
        busy       = rx_valid && !dropping && !have;
        take       = accept && !act_valid;
        close_addr = act_valid ? act_addr : pf_addr;
        use_ptr    = act_valid ? act_ptr  : pf_ptr;
        use_wrap   = act_valid ? act_wrap : pf_wrap;
        base_cnt   = act_valid ? act_cnt  : '0;
        cnt_n      = base_cnt + LEN_W'(1);
        flen_n     = frame_len + LEN_W'(1);
        close      = accept && (rx_last || cnt_n == buf_len);
        close_word.status = make_status(use_wrap, rx_last, first_pend);
        close_word.length = rx_last ? flen_n : cnt_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_valid  <= 1'b0;
            act_addr   <= '0;
            act_ptr    <= '0;
            act_wrap   <= 1'b0;
            act_cnt    <= '0;
            frame_len  <= '0;
            first_pend <= 1'b1;
            dropping   <= 1'b0;
            bw_valid   <= 1'b0;
            bw_addr    <= '0;
            bw_data    <= '0;
            irq_frame  <= 1'b0;
            err_busy   <= 1'b0;
        end else begin
            bw_valid  <= accept;
            bw_addr   <= use_ptr + PTR_W'(base_cnt);
            bw_data   <= rx_data;
            irq_frame <= accept && rx_last;
            err_busy  <= busy;
            if (accept) begin
                if (close) begin
                    act_valid  <= 1'b0;
                    first_pend <= rx_last;
                    frame_len  <= rx_last ? '0 : flen_n;
                end else begin
                    act_valid <= 1'b1;
                    act_addr  <= close_addr;
                    act_ptr   <= use_ptr;
                    act_wrap  <= use_wrap;
                    act_cnt   <= cnt_n;
                    frame_len <= flen_n;
                end
            end else if (busy) begin
                dropping   <= !rx_last;
                frame_len  <= '0;
                first_pend <= 1'b1;
            end else if (rx_valid && dropping && rx_last) begin
                dropping <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxbd_port_arb.sv
module rxbd_port_arb
    import rxbd_pkg::*;
#(
    parameter int DA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            close,
    input  logic [DA_W-1:0] close_addr,
    input  desc_w0_t        close_word,
    input  logic            rd_req,
    input  logic [DA_W-1:0] rd_addr,
    output logic            grant,
    output logic            dram_req,
    output logic            dram_we,
    output logic [DA_W-1:0] dram_addr,
    output logic [31:0]     dram_wdata
);

    logic            wb_pend;
    logic [DA_W-1:0] wb_addr;
    desc_w0_t        wb_word;

    // A new close overrides the pending flag; the old write issues this cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_pend <= 1'b0;
            wb_addr <= '0;
            wb_word <= '0;
        end else if (close) begin
            wb_pend <= 1'b1;
            wb_addr <= close_addr;
            wb_word <= close_word;
        end else begin
            wb_pend <= 1'b0;
        end
    end

    always_comb begin
        grant      = !wb_pend;
        dram_req   = wb_pend || rd_req;
        dram_we    = wb_pend;
        dram_addr  = wb_pend ? wb_addr : rd_addr;
        dram_wdata = wb_word;
    end

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
    import rxbd_pkg::*;
#(
    parameter int DA_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DA_W-1:0]  tbl_base,
    input  logic [LEN_W-1:0] buf_len,
    output logic             dram_req,
    output logic             dram_we,
    output logic [DA_W-1:0]  dram_addr,
    output logic [31:0]      dram_wdata,
    input  logic [31:0]      dram_rdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    output logic             bw_valid,
    output logic [PTR_W-1:0] bw_addr,
    output logic [7:0]       bw_data,
    output logic             irq_frame,
    output logic             err_busy
);

    logic             grant, rd_req, take, close;
    logic [DA_W-1:0]  rd_addr, pf_addr, close_addr;
    logic [PTR_W-1:0] pf_ptr;
    logic             pf_valid, pf_wrap;
    desc_w0_t         close_word;

    rxbd_prefetch #(.DA_W(DA_W)) u_pf (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .grant(grant),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(dram_rdata),
        .take(take), .pf_valid(pf_valid), .pf_addr(pf_addr),
        .pf_ptr(pf_ptr), .pf_wrap(pf_wrap)
    );

    rxbd_fill #(.DA_W(DA_W)) u_fill (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .buf_len(buf_len), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_ptr(pf_ptr), .pf_wrap(pf_wrap),
        .take(take), .close(close), .close_addr(close_addr),
        .close_word(close_word), .bw_valid(bw_valid), .bw_addr(bw_addr),
        .bw_data(bw_data), .irq_frame(irq_frame), .err_busy(err_busy)
    );

    rxbd_port_arb #(.DA_W(DA_W)) u_arb (
        .clk(clk), .rst(rst), .close(close), .close_addr(close_addr),
        .close_word(close_word), .rd_req(rd_req), .rd_addr(rd_addr),
        .grant(grant), .dram_req(dram_req), .dram_we(dram_we),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata)
    );

endmodule

// File: rtl/rxbd_checker.sv
module rxbd_checker (
    input logic        clk,
    input logic        rst,
    input logic        dram_req,
    input logic        dram_we,
    input logic [2:0]  desc_lo,
    input logic        wb_empty,
    input logic [15:0] wb_len,
    input logic        rx_valid,
    input logic        rx_last,
    input logic        bw_valid,
    input logic        irq_frame,
    input logic        err_busy
);

    p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        dram_req |-> desc_lo[1:0] == 2'b00);

    p_wb_word0_r11: assert property (@(posedge clk) disable iff (rst)
        (dram_req && dram_we) |-> desc_lo == 3'b000);

    p_wb_clears_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (dram_req && dram_we) |-> !wb_empty);

    p_wb_len_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        (dram_req && dram_we) |-> wb_len != 16'd0);

    p_bw_from_rx_r3: assert property (@(posedge clk) disable iff (rst)
        bw_valid |-> $past(rx_valid));

    p_busy_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        err_busy |-> (!bw_valid && $past(rx_valid)));

    p_irq_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        irq_frame |-> $past(rx_valid && rx_last));

endmodule

bind rxbd_engine rxbd_checker u_chk (
    .clk(clk), .rst(rst), .dram_req(dram_req), .dram_we(dram_we),
    .desc_lo(dram_addr[2:0]), .wb_empty(dram_wdata[31]),
    .wb_len(dram_wdata[15:0]), .rx_valid(rx_valid), .rx_last(rx_last),
    .bw_valid(bw_valid), .irq_frame(irq_frame), .err_busy(err_busy)
);

// File: tb/sim_rxbd_engine.sv
`timescale 1ns/1ps
module sim_rxbd_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tbl_base = 8'h40;
    logic [15:0] buf_len = 16'd8;
    logic        dram_req, dram_we;
    logic [7:0]  dram_addr;
    logic [31:0] dram_wdata;
    logic [31:0] dram_rdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        bw_valid;
    logic [31:0] bw_addr;
    logic [7:0]  bw_data;
    logic        irq_frame, err_busy;

    always #5 clk = ~clk;

    rxbd_engine u0 (
        .clk(clk), .rst(rst), .tbl_base(tbl_base), .buf_len(buf_len),
        .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data),
        .irq_frame(irq_frame), .err_busy(err_busy)
    );

    logic [31:0] dmem [0:63];
    logic [7:0]  bmem [0:4095];
    int          n_chk = 0, n_fail = 0;
    int          bw_cnt = 0, irq_cnt = 0, err_cnt = 0;
    logic        first_seen = 1'b0;
    logic [7:0]  first_addr = '0;
    logic        done = 1'b0;

    // Descriptor RAM and buffer memory models.
    always @(posedge clk) begin
        if (dram_req && dram_we) dmem[dram_addr[7:2]] <= dram_wdata;
        if (dram_req && !dram_we) dram_rdata <= dmem[dram_addr[7:2]];
        if (bw_valid) begin
            bmem[bw_addr[11:0]] <= bw_data;
            bw_cnt <= bw_cnt + 1;
        end
        if (irq_frame) irq_cnt <= irq_cnt + 1;
        if (err_busy) err_cnt <= err_cnt + 1;
        if (rst) first_seen <= 1'b0;
        else if (!first_seen && dram_req) begin
            first_seen <= 1'b1;
            first_addr <= dram_addr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_desc(input logic [7:0] a, input logic [15:0] st, input logic [31:0] p);
        dmem[a[7:2]]      = {st, 16'h0000};
        dmem[a[7:2] + 1]  = p;
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = seed + 8'(i);
            rx_last  = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic chk_bytes(input string req, input int base, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++)
            chk(req, {24'h0, bmem[base + i]}, {24'h0, seed + 8'(i)});
    endtask

    task automatic do_reset(input logic [7:0] base);
        rst = 1'b1;
        tbl_base = base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: quiet outputs and first read at the base.
    task automatic t_reset();
        set_desc(8'h40, 16'h8000, 32'h100);
        set_desc(8'h48, 16'h8000, 32'h200);
        set_desc(8'h50, 16'h8000, 32'h300);
        set_desc(8'h58, 16'hA000, 32'h400);
        do_reset(8'h40);
        @(negedge clk);
        chk("R1 bw_valid", {31'h0, bw_valid}, 32'h0);
        chk("R1 irq", {31'h0, irq_frame}, 32'h0);
        chk("R1 err", {31'h0, err_busy}, 32'h0);
        repeat (6) @(negedge clk);
        chk("R1 first read", {24'h0, first_addr}, 32'h40);
    endtask

    // R3 R5 R6 R9 R11: short frame in one buffer.
    task automatic t_single();
        send_frame(5, 8'h10);
        chk("R5 R6 D0 word0", dmem[8'h40 >> 2], 32'h0C000005);
        chk("R11 D0 pointer", dmem[8'h44 >> 2], 32'h100);
        chk_bytes("R3", 32'h100, 5, 8'h10);
        chk("R9 irq count", irq_cnt, 1);
    endtask

    // R4 R5 R6 R2: frame across three buffers, last has wrap.
    task automatic t_multi();
        send_frame(20, 8'h30);
        chk("R4 R5 D1", dmem[8'h48 >> 2], 32'h04000008);
        chk("R4 R5 D2", dmem[8'h50 >> 2], 32'h00000008);
        chk("R2 R6 D3", dmem[8'h58 >> 2], 32'h28000014);
        chk_bytes("R3 b1", 32'h200, 8, 8'h30);
        chk_bytes("R3 b2", 32'h300, 8, 8'h38);
        chk_bytes("R3 b3", 32'h400, 4, 8'h40);
        chk("R3 write count", bw_cnt, 25);
        chk("R9 irq count", irq_cnt, 2);
    endtask

    // R2 R8: walk wraps to base and re-polls until re-armed.
    task automatic t_ring();
        set_desc(8'h40, 16'h8000, 32'h500);
        repeat (10) @(negedge clk);
        send_frame(3, 8'h50);
        chk("R2 R8 D0 again", dmem[8'h40 >> 2], 32'h0C000003);
        chk_bytes("R2", 32'h500, 3, 8'h50);
    endtask

    // R7 R8: busy frame dropped, then resume with first set.
    task automatic t_busy();
        send_frame(6, 8'h70);
        chk("R7 err count", err_cnt, 1);
        chk("R7 no writes", bw_cnt, 28);
        chk("R7 no irq", irq_cnt, 3);
        chk("R7 D1 untouched", dmem[8'h48 >> 2], 32'h04000008);
        set_desc(8'h48, 16'h8000, 32'h600);
        repeat (10) @(negedge clk);
        send_frame(4, 8'h90);
        chk("R8 D1 resumed", dmem[8'h48 >> 2], 32'h0C000004);
        chk_bytes("R8", 32'h600, 4, 8'h90);
    endtask

    // R7: busy in the middle of a frame.
    task automatic t_busy_mid();
        set_desc(8'h50, 16'h8000, 32'h700);
        repeat (10) @(negedge clk);
        send_frame(12, 8'hA0);
        chk("R7 mid D2", dmem[8'h50 >> 2], 32'h04000008);
        chk("R7 mid err", err_cnt, 2);
        chk("R7 mid writes", bw_cnt, 40);
        chk("R7 mid irq", irq_cnt, 4);
        chk("R7 mid D3 untouched", dmem[8'h58 >> 2], 32'h28000014);
    endtask

    // R10 R4: two-descriptor ring, exact-length frame.
    task automatic t_two();
        set_desc(8'h80, 16'h8000, 32'h800);
        set_desc(8'h88, 16'hA000, 32'h900);
        do_reset(8'h80);
        repeat (10) @(negedge clk);
        send_frame(8, 8'hB0);
        chk("R4 exact length", dmem[8'h80 >> 2], 32'h0C000008);
        send_frame(4, 8'hC0);
        chk("R10 E1", dmem[8'h88 >> 2], 32'h2C000004);
        set_desc(8'h80, 16'h8000, 32'hA00);
        repeat (10) @(negedge clk);
        send_frame(4, 8'hD0);
        chk("R10 E0 reuse", dmem[8'h80 >> 2], 32'h0C000004);
        chk_bytes("R10", 32'hA00, 4, 8'hD0);
        chk_bytes("R10 E1 data", 32'h900, 4, 8'hC0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) dmem[i] = '0;
        for (int i = 0; i < 4096; i++) bmem[i] = '0;
        t_reset();
        t_single();
        t_multi();
        t_ring();
        t_busy();
        t_busy_mid();
        t_two();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule